// File: doc/BRIEF.md
# Vertical Flicker Filter and Field Interlacer

This block sits in front of a TV encoder and takes a progressive 4:2:2 stream of 8-bit samples. The samples arrive in the order Cb, Y, Cr, Y. Each frame is reduced to one interlaced field, and the parity of that field alternates from one frame to the next. Every output line is smoothed vertically using the lines around it. Two line stores hold the two previous lines. Output line m is built while input line m+1 streams in. The bottom line of a frame is produced from the stores in the idle time after the frame's last sample.

Two filter modes are available. The first is a fixed three-tap kernel. The second is a two-tap blend with a programmable weight, followed by an optional gamma lookup on luma. The lookup table is loaded through a simple write port. A per-line adjust code can remove one output line or add a line that the field would normally leave out. A standard select picks the 525-style or 625-style active line count. A progressive pass mode emits every line.

Top module: `vflick_interlacer`

## Requirements
- R1: After reset, out_valid is low and stays low until filtered data is available.
- R2: Three-tap mode: output line m is (top + 2*mid + bot + 2) >> 2, where top is line m-1, mid is line m and bot is line m+1. It is computed per sample position, so a position j only ever combines samples at position j. Cb, Y and Cr are therefore never mixed.
- R3: At the frame edges the missing neighbour is replaced by the edge line itself. Line 0 uses line 0 as its top, and the last line uses itself as its bottom.
- R4: Interlaced mode: frame k after reset (k counted from 0) emits only lines whose index parity equals k mod 2. out_field equals k mod 2.
- R5: Samples of output line m leave one cycle after the matching sample of input line m+1. The last line of a frame is produced in W consecutive cycles, starting two cycles after the frame's last input sample. Nothing else is emitted.
- R6: Two-tap mode: output is (a*mid + (16-a)*bot + 8) >> 4, with a = cfg_alpha. Values of cfg_alpha above 16 act as 16.
- R7: In two-tap mode with cfg_gamma_en high, luma samples are replaced by table[value]. Luma samples are the odd positions in a line, with position 0 = Cb. Chroma samples pass through unchanged. In three-tap mode cfg_gamma_en has no effect.
- R8: A cycle with gam_we high writes gam_wdata into table entry gam_addr.
- R9: line_adj is sampled with in_sol of input line m+1 and acts on output line m. Code 01 suppresses line m, code 10 forces line m out, and code 00 leaves the field selection alone. The bottom line is never adjusted.
- R10: A frame holds LINES_625 lines when cfg_std625 is high and LINES_525 lines otherwise.
- R11: When cfg_prog is high, every line of the frame is emitted and out_field is 0.
- R12: out_sol marks position 0 of every emitted line. out_sof marks position 0 of the first emitted line of each field.
- R13: All cfg_* inputs are captured on the in_sof sample and hold for that whole frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample present |
| in_data | input | 8 | Input sample |
| in_sol | input | 1 | First sample of a line |
| in_sof | input | 1 | First sample of a frame (with in_sol) |
| line_adj | input | 2 | Drop/add code, read with in_sol |
| cfg_std625 | input | 1 | Line count select |
| cfg_prog | input | 1 | Progressive pass mode |
| cfg_two_tap | input | 1 | Two-tap mode select |
| cfg_gamma_en | input | 1 | Gamma lookup enable |
| cfg_alpha | input | 5 | Two-tap weight, 0..16 |
| gam_we | input | 1 | Table write strobe |
| gam_addr | input | 8 | Table write index |
| gam_wdata | input | 8 | Table write value |
| out_valid | output | 1 | Output sample present |
| out_data | output | 8 | Output sample |
| out_sol | output | 1 | First sample of an output line |
| out_sof | output | 1 | First sample of a field |
| out_field | output | 1 | Field parity |

## Verification
The assertions assume that input lines are exactly LINE_SAMPLES long, with in_sol on position 0 and only there. They also assume that in_valid stays low for the W cycles of bottom-line generation after each frame. The stimulus builds every line at full length and sets in_sof only together with in_sol. It may insert idle cycles between lines, but it leaves at least W+4 idle cycles after each frame before the next in_sof.

// File: rtl/vflick_interlacer.sv
module vflick_interlacer #(
  parameter int LINE_SAMPLES = 1440,
  parameter int LINES_525    = 480,
  parameter int LINES_625    = 576,
  parameter int TAP_OUTER    = 1,
  parameter int TAP_CENTER   = 2,
  parameter int TAP_SHIFT    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       in_sol,
  input  logic       in_sof,
  input  logic [1:0] line_adj,
  input  logic       cfg_std625,
  input  logic       cfg_prog,
  input  logic       cfg_two_tap,
  input  logic       cfg_gamma_en,
  input  logic [4:0] cfg_alpha,
  input  logic       gam_we,
  input  logic [7:0] gam_addr,
  input  logic [7:0] gam_wdata,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sol,
  output logic       out_sof,
  output logic       out_field
);
  localparam int SW   = (LINE_SAMPLES > 1) ? $clog2(LINE_SAMPLES) : 1;
  localparam int LMAX = (LINES_625 > LINES_525) ? LINES_625 : LINES_525;
  localparam int LW   = $clog2(LMAX + 2);
  localparam int RND3 = (TAP_SHIFT > 0) ? (1 << (TAP_SHIFT - 1)) : 0;
  localparam logic [SW-1:0] LAST_POS = SW'(LINE_SAMPLES - 1);

  logic [7:0] buf0 [LINE_SAMPLES];
  logic [7:0] buf1 [LINE_SAMPLES];
  logic [7:0] gtab [256];

  logic [SW-1:0] scnt, ocnt;
  logic [LW-1:0] lcnt;
  logic par, seen, flushing, emit_q, first_pend;
  logic std_q, prog_q, two_q, gam_q;
  logic [4:0] alpha_q;

  logic [SW-1:0] pos;
  logic [LW-1:0] lcur, cur_line, nline, mline;
  logic [7:0] mid, old, top, bot;
  logic have_out, base_emit, emit_calc, emit_now, frame_end;
  logic [19:0] t3, t2, sum;
  logic [4:0] a_eff;
  logic [7:0] sat, res;

  assign lcur     = std_q ? LW'(LINES_625) : LW'(LINES_525);
  assign pos      = (in_sol && !flushing) ? '0 : scnt;
  assign cur_line = in_sof ? '0 : (in_sol ? lcnt + 1'b1 : lcnt);
  assign nline    = flushing ? lcur : cur_line;
  assign mline    = nline - 1'b1;

  assign mid = nline[0] ? buf0[pos] : buf1[pos];
  assign old = nline[0] ? buf1[pos] : buf0[pos];
  assign top = (nline == LW'(1)) ? mid : old;
  assign bot = flushing ? mid : in_data;

  assign have_out  = flushing || (in_valid && nline != '0);
  assign base_emit = prog_q || (mline[0] == par);
  assign emit_calc = (line_adj == 2'b01) ? 1'b0 : (line_adj == 2'b10) ? 1'b1 : base_emit;
  assign emit_now  = flushing ? base_emit : (in_sol ? emit_calc : emit_q);
  assign frame_end = in_valid && !flushing && pos == LAST_POS && cur_line == lcur - 1'b1;

  assign t3 = 20'(TAP_OUTER) * 20'(top) + 20'(TAP_CENTER) * 20'(mid)
            + 20'(TAP_OUTER) * 20'(bot) + 20'(RND3);
  assign a_eff = (alpha_q > 5'd16) ? 5'd16 : alpha_q;
  assign t2 = 20'(a_eff) * 20'(mid) + (20'd16 - 20'(a_eff)) * 20'(bot) + 20'd8;
  assign sum = two_q ? (t2 >> 4) : (t3 >> TAP_SHIFT);
  assign sat = (|sum[19:8]) ? 8'hFF : sum[7:0];
  assign res = (two_q && gam_q && pos[0]) ? gtab[sat] : sat;

  always_ff @(posedge clk) begin
    if (gam_we) gtab[gam_addr] <= gam_wdata;
  end

  always_ff @(posedge clk) begin
    if (in_valid && !flushing) begin
      if (nline[0]) buf1[pos] <= in_data;
      else          buf0[pos] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scnt <= '0; lcnt <= '0; par <= 1'b0; seen <= 1'b0;
      flushing <= 1'b0; emit_q <= 1'b0; first_pend <= 1'b0;
      std_q <= 1'b0; prog_q <= 1'b0; two_q <= 1'b0; gam_q <= 1'b0; alpha_q <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sol <= 1'b0; out_sof <= 1'b0; out_field <= 1'b0;
    end else begin
      out_valid <= have_out && emit_now;
      out_data  <= res;
      out_sol   <= have_out && emit_now && pos == '0;
      out_sof   <= have_out && emit_now && pos == '0 && first_pend;
      out_field <= prog_q ? 1'b0 : par;
      if (have_out && emit_now && pos == '0) first_pend <= 1'b0;
      if (flushing) begin
        scnt <= (scnt == LAST_POS) ? '0 : scnt + 1'b1;
        if (scnt == LAST_POS) flushing <= 1'b0;
      end else if (in_valid) begin
        scnt <= (pos == LAST_POS) ? '0 : pos + 1'b1;
        if (in_sol) emit_q <= emit_calc;
        if (frame_end) flushing <= 1'b1;
        if (in_sof) begin
          lcnt <= '0;
          par <= seen ? ~par : 1'b0;
          seen <= 1'b1;
          first_pend <= 1'b1;
          std_q <= cfg_std625; prog_q <= cfg_prog; two_q <= cfg_two_tap;
          gam_q <= cfg_gamma_en; alpha_q <= cfg_alpha;
        end else if (in_sol) begin
          lcnt <= lcnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ocnt <= '0;
    else if (out_valid) ocnt <= (ocnt == LAST_POS) ? '0 : ocnt + 1'b1;
  end

  AST_SOL_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !flushing) |-> (in_sol == (scnt == '0))) else $error("sol misaligned"); // R12
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !in_valid) else $error("input during bottom line"); // R5
  AST_OUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) || $past(flushing))) else $error("output without cause"); // R5
  AST_PROG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prog_q) |-> !out_field) else $error("field tag in pass mode"); // R11
  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_sof && $past(out_valid)) |-> (out_field == $past(out_field))) else $error("field flip"); // R4
  AST_SOL_POS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sol == (ocnt == '0))) else $error("out_sol off position"); // R12
endmodule

// File: tb/tb_vflick_interlacer.sv
`timescale 1ns/1ps
module tb_vflick_interlacer;
  localparam int W  = 8;
  localparam int L5 = 4;
  localparam int L6 = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, in_valid, in_sol, in_sof, cfg_std625, cfg_prog, cfg_two_tap, cfg_gamma_en, gam_we;
  logic [7:0] in_data, gam_addr, gam_wdata, out_data;
  logic [1:0] line_adj;
  logic [4:0] cfg_alpha;
  logic out_valid, out_sol, out_sof, out_field;

  vflick_interlacer #(.LINE_SAMPLES(W), .LINES_525(L5), .LINES_625(L6)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_sol(in_sol),
    .in_sof(in_sof), .line_adj(line_adj), .cfg_std625(cfg_std625), .cfg_prog(cfg_prog),
    .cfg_two_tap(cfg_two_tap), .cfg_gamma_en(cfg_gamma_en), .cfg_alpha(cfg_alpha),
    .gam_we(gam_we), .gam_addr(gam_addr), .gam_wdata(gam_wdata), .out_valid(out_valid),
    .out_data(out_data), .out_sol(out_sol), .out_sof(out_sof), .out_field(out_field));

  int checks = 0, fails = 0, fcount = 0;
  logic [10:0] exq[$];
  string tq[$];

  function automatic int gfun(int v); return (v * 3 + 17) % 256; endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin : mon
    logic [10:0] e;
    string t;
    if (rst_n && out_valid) begin
      if (exq.size() == 0) chk(0, "R5 unexpected output", out_data, 0);
      else begin
        e = exq.pop_front();
        t = tq.pop_front();
        chk({out_field, out_sof, out_sol, out_data} == e, t, {out_field, out_sof, out_sol, out_data}, e);
      end
    end
  end

  task automatic run_frame(int nl, bit std, bit prog, bit two, bit gen, int alpha, int seed,
                           int drop_at, int add_at, bit chk_flush, bit r13_change, string tag);
    int pix[L6][W];
    int par, a, t, c, b, v;
    bit e, first;
    par = fcount % 2;
    fcount++;
    for (int l = 0; l < nl; l++)
      for (int j = 0; j < W; j++)
        pix[l][j] = (seed * 37 + l * 61 + j * 29 + l * j * 13) % 256;
    if (seed % 2 == 1) for (int j = 0; j < W; j++) pix[1][j] = 255;
    first = 1;
    for (int m = 0; m < nl; m++) begin
      e = prog || (m % 2 == par);
      if (m == drop_at) e = 0;
      if (m == add_at) e = 1;
      if (e) begin
        for (int j = 0; j < W; j++) begin
          c = pix[m][j];
          t = pix[(m > 0) ? m - 1 : 0][j];
          b = pix[(m < nl - 1) ? m + 1 : m][j];
          if (two) begin
            a = (alpha > 16) ? 16 : alpha;
            v = (a * c + (16 - a) * b + 8) >> 4;
            if (gen && j % 2 == 1) v = gfun(v);
          end else v = (t + 2 * c + b + 2) >> 2;
          exq.push_back({(prog ? 1'b0 : 1'(par)), (first && j == 0), (j == 0), 8'(v)});
          tq.push_back(tag);
        end
        first = 0;
      end
    end
    for (int l = 0; l < nl; l++) begin
      for (int j = 0; j < W; j++) begin
        @(negedge clk);
        if (l == 0 && j == 0) begin
          cfg_std625 = std; cfg_prog = prog; cfg_two_tap = two;
          cfg_gamma_en = gen; cfg_alpha = 5'(alpha);
        end
        if (l == 0 && j == 1 && r13_change) begin
          cfg_two_tap = ~two; cfg_alpha = 5'd3; cfg_prog = ~prog;
        end
        in_valid = 1; in_data = 8'(pix[l][j]); in_sol = (j == 0); in_sof = (l == 0 && j == 0);
        line_adj = 2'b00;
        if (j == 0 && l > 0 && l - 1 == drop_at) line_adj = 2'b01;
        if (j == 0 && l > 0 && l - 1 == add_at) line_adj = 2'b10;
      end
      if (l == 1 && l < nl - 1) begin
        @(negedge clk);
        in_valid = 0; in_sol = 0; in_sof = 0; line_adj = 2'b11;
      end
    end
    @(negedge clk);
    in_valid = 0; in_sol = 0; in_sof = 0; line_adj = 0;
    if (chk_flush) begin
      chk(!out_valid, "R5 bottom line not yet started", out_valid, 0);
      @(negedge clk);
      chk(out_valid && out_sol, "R5 bottom line starts two cycles after last sample", {out_valid, out_sol}, 3);
    end
    repeat (W + 4) @(negedge clk);
  endtask

  task automatic load_gamma();
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      gam_we = 1; gam_addr = 8'(k); gam_wdata = 8'(gfun(k));
    end
    @(negedge clk);
    gam_we = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 0; in_valid = 0; in_data = 0; in_sol = 0; in_sof = 0; line_adj = 0;
    cfg_std625 = 0; cfg_prog = 0; cfg_two_tap = 0; cfg_gamma_en = 0; cfg_alpha = 0;
    gam_we = 0; gam_addr = 0; gam_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid low after reset", out_valid, 0);
    chk(out_data == 0, "R1 out_data cleared", out_data, 0);
    run_frame(L5, 0, 0, 0, 0, 0, 2, -1, -1, 0, 0, "R2 R3 R4 three-tap even field");
    run_frame(L5, 0, 0, 0, 0, 0, 3, -1, -1, 1, 0, "R3 R4 R5 odd field bottom edge");
    run_frame(L6, 1, 0, 1, 0, 5, 4, -1, -1, 0, 0, "R6 R10 two-tap 625-line");
    load_gamma();
    run_frame(L6, 1, 0, 1, 1, 20, 5, -1, -1, 1, 0, "R6 R7 R8 gamma on luma");
    run_frame(L5, 0, 0, 0, 1, 9, 6, -1, -1, 0, 0, "R7 gamma ignored in three-tap");
    run_frame(L5, 0, 1, 0, 0, 0, 7, -1, -1, 0, 0, "R11 progressive pass");
    run_frame(L5, 0, 0, 0, 0, 0, 8, 0, 1, 0, 0, "R9 R12 drop and add lines");
    run_frame(L5, 0, 0, 0, 0, 0, 9, -1, -1, 1, 1, "R13 config held for frame");
    repeat (10) @(negedge clk);
    chk(exq.size() == 0, "R5 all expected output produced", exq.size(), 0);
    finish_run();
  end
endmodule